// File: doc/BRIEF.md
# Supply-Fault Access Gate and Reset Sequencer

This block stands between the external strobes of a byte-wide memory and clock device and the internal storage port. It watches two digitized supply comparator outputs: one says the supply is below the write-protect level, the other says it is below the battery level. While the supply is below the write-protect level, every access is blocked and the reset output is held low. When the supply comes back, blocking and reset are held for a recovery interval. The interval is counted in ticks of a slow enable, and a new fault during the count starts it over.

With power good, the strobes are decoded into deselect, write, read with the data bus driven, and read with the bus undriven. The block also gives a one-cycle pulse on the cycle in which a write starts, which is the later of the two strobes going active. It selects the backup supply only when the supply is below both comparator levels, so the switch happens at the lower of the two. The backup source is armed by the first valid power-up and stays armed until a cold-start input disarms it. The ordinary reset does not disarm it.

Top module: `pwr_gate_seq`

## Requirements
- R1: While `vcc_lt_pf` is 1, `int_ce_n` is 1 and `mem_rd`, `mem_wr`, `dq_oe` and `wr_start` are 0 in the same cycle, whatever the strobe levels.
- R2: `rst_out_n` is 0 in every cycle in which `vcc_lt_pf` is 1, including the first cycle of a fault.
- R3: After `vcc_lt_pf` returns to 0, `rst_out_n` stays 0 and access stays blocked until REC_TICKS cycles with `tick`=1 have been sampled in the recovering state. Both are released right after the clock edge that samples the last of those ticks.
- R4: A cycle with `vcc_lt_pf`=1 during the recovery count discards the ticks counted so far. The full REC_TICKS ticks are needed again after the supply next returns.
- R5: `bat_sel` is 1 exactly when `armed` is 1 and both `vcc_lt_pf` and `vcc_lt_so` are 1.
- R6: `armed` is cleared only by `cold_n`=0. It is set by the clock edge after the first cycle with `vcc_lt_pf`=0. It then stays 1 through supply faults and through `rst_n` pulses.
- R7: With access released, the strobes decode as follows. If `ext_ce_n`=1: deselect, with all access outputs 0 and `int_ce_n`=1. If `ext_ce_n`=0 and `ext_we_n`=0: write, with `mem_wr`=1. If `ext_ce_n`=0 and `ext_we_n`=1: read, with `mem_rd`=1, and `dq_oe`=1 only when `ext_oe_n`=0. In every non-deselect mode `int_ce_n`=0.
- R8: `wr_start` is 1 only in the first cycle of each run of cycles with `mem_wr`=1, whichever of `ext_ce_n` and `ext_we_n` went low last.
- R9: After `rst_n` is released, the block is in the fault state. `rst_out_n` stays 0 even with a good supply until the R3 recovery has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| cold_n | input | 1 | Asynchronous active-low cold start, disarms the backup source |
| tick | input | 1 | Slow enable that paces the recovery count |
| vcc_lt_pf | input | 1 | Supply below the write-protect level |
| vcc_lt_so | input | 1 | Supply below the battery level |
| ext_ce_n | input | 1 | External chip enable, active low |
| ext_oe_n | input | 1 | External output enable, active low |
| ext_we_n | input | 1 | External write enable, active low |
| int_ce_n | output | 1 | Gated chip enable to the internal port, active low |
| mem_rd | output | 1 | Read access in progress |
| mem_wr | output | 1 | Write access in progress |
| dq_oe | output | 1 | Drive the data bus |
| wr_start | output | 1 | First cycle of a write |
| rst_out_n | output | 1 | Reset output, active low |
| bat_sel | output | 1 | Run from the backup source |
| armed | output | 1 | Backup source has been armed |

## Verification
The hardest case to reach is a fault that arrives part way through a recovery count. Afterwards, the release must come a full REC_TICKS ticks later and not at the point where the interrupted count would have ended. The stimulus lets some ticks accumulate and pulses `vcc_lt_pf` for one cycle. It then gives exactly one tick fewer than needed and checks that reset is still low, then gives the last tick and checks the release. Keeping `armed` set across an `rst_n` pulse, and clearing it only by cold start, is driven in the same directed way. The strobe decoding is covered by random strobe patterns, both with access released and during a fault.

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter int REC_TICKS = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_n,
  input  logic tick,
  input  logic vcc_lt_pf,
  input  logic vcc_lt_so,
  input  logic ext_ce_n,
  input  logic ext_oe_n,
  input  logic ext_we_n,
  output logic int_ce_n,
  output logic mem_rd,
  output logic mem_wr,
  output logic dq_oe,
  output logic wr_start,
  output logic rst_out_n,
  output logic bat_sel,
  output logic armed
);
  localparam int CNT_W = (REC_TICKS > 1) ? $clog2(REC_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_TICKS - 1);

  typedef enum logic [1:0] {S_FAULT, S_RECOVER, S_READY} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;
  logic             open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FAULT;
      cnt   <= '0;
    end else begin
      case (state)
        S_FAULT:
          if (!vcc_lt_pf) begin
            state <= S_RECOVER;
            cnt   <= '0;
          end
        S_RECOVER:
          if (vcc_lt_pf) state <= S_FAULT;
          else if (tick) begin
            if (cnt == LAST) state <= S_READY;
            else cnt <= cnt + 1'b1;
          end
        S_READY:
          if (vcc_lt_pf) state <= S_FAULT;
        default: state <= S_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge cold_n) begin
    if (!cold_n) armed <= 1'b0;
    else if (!vcc_lt_pf) armed <= 1'b1;
  end

  assign open_q    = (state == S_READY);
  assign rst_out_n = open_q & ~vcc_lt_pf;
  assign int_ce_n  = ~(rst_out_n & ~ext_ce_n);
  assign mem_wr    = ~int_ce_n & ~ext_we_n;
  assign mem_rd    = ~int_ce_n & ext_we_n;
  assign dq_oe     = mem_rd & ~ext_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= mem_wr;
  end

  assign wr_start = mem_wr & ~wr_q;
  assign bat_sel  = armed & vcc_lt_pf & vcc_lt_so;

  p_fault_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_lt_pf |-> (int_ce_n && !mem_wr && !mem_rd && !dq_oe && !wr_start));
  p_fault_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_lt_pf |-> !rst_out_n);
  p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(tick) && !$past(vcc_lt_pf)));
  p_fault_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_lt_pf |=> !rst_out_n);
  p_unarmed_no_bat_r5: assert property (@(posedge clk) disable iff (!cold_n)
    !armed |-> !bat_sel);
  p_armed_sticky_r6: assert property (@(posedge clk) disable iff (!cold_n)
    armed |=> armed);
  p_arm_cause_r6: assert property (@(posedge clk) disable iff (!cold_n)
    $rose(armed) |-> !$past(vcc_lt_pf));
  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !dq_oe);
  p_single_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && mem_wr) |=> !(wr_start && $stable(mem_wr)));
endmodule

// File: tb/tb_pwr_gate_seq.sv
module tb_pwr_gate_seq;
  localparam int REC = 35;

  logic clk = 1'b0;
  logic rst_n, cold_n, tick, vcc_lt_pf, vcc_lt_so;
  logic ext_ce_n, ext_oe_n, ext_we_n;
  logic int_ce_n, mem_rd, mem_wr, dq_oe, wr_start, rst_out_n, bat_sel, armed;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_gate_seq #(.REC_TICKS(REC)) dut (
    .clk(clk), .rst_n(rst_n), .cold_n(cold_n), .tick(tick),
    .vcc_lt_pf(vcc_lt_pf), .vcc_lt_so(vcc_lt_so),
    .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
    .int_ce_n(int_ce_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .dq_oe(dq_oe),
    .wr_start(wr_start), .rst_out_n(rst_out_n), .bat_sel(bat_sel), .armed(armed)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mode(input logic open, input logic ce, input logic oe, input logic we);
    logic sel;
    sel = open & ~ce;
    return {~sel, sel & we, sel & ~we, sel & we & ~oe};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step();
      tick = 1'b0; step();
    end
  endtask

  task automatic chk_mode(input string req, input logic open);
    logic [3:0] e;
    #1;
    e = exp_mode(open, ext_ce_n, ext_oe_n, ext_we_n);
    chk(req, {int_ce_n, mem_rd, mem_wr, dq_oe}, e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; cold_n = 0; tick = 0; vcc_lt_pf = 1; vcc_lt_so = 1;
    ext_ce_n = 1; ext_oe_n = 1; ext_we_n = 1;
    repeat (3) step();
    chk("R2 reset low at start", rst_out_n, 0);
    chk("R6 disarmed at cold start", armed, 0);
    chk("R5 no backup when disarmed", bat_sel, 0);
    rst_n = 1; cold_n = 1;
    step();
    chk("R6 stays disarmed while supply low", armed, 0);
    ext_ce_n = 0; ext_oe_n = 0;
    #1 chk("R1 read blocked in fault", {int_ce_n, dq_oe}, 2'b10);

    step();
    vcc_lt_pf = 0; vcc_lt_so = 0;
    #1 chk("R9 reset still low after supply good", rst_out_n, 0);
    chk("R3 access blocked before recovery", int_ce_n, 1);
    step();
    chk("R6 armed after first good supply", armed, 1);
    step();
    give_ticks(10);
    chk("R3 still low mid count", rst_out_n, 0);
    vcc_lt_pf = 1;
    #1 chk("R2 reset during recovery fault", rst_out_n, 0);
    step();
    vcc_lt_pf = 0;
    step(); step();
    give_ticks(REC - 1);
    chk("R4 count restarted after fault", rst_out_n, 0);
    give_ticks(1);
    chk("R3 released after full count", rst_out_n, 1);

    for (int i = 0; i < 150; i++) begin
      {ext_ce_n, ext_oe_n, ext_we_n} = 3'($urandom_range(0, 7));
      chk_mode("R7 strobe decode", 1'b1);
      step();
    end

    ext_ce_n = 1; ext_oe_n = 1; ext_we_n = 1; step();
    ext_ce_n = 0; step();
    ext_we_n = 0;
    #1 chk("R8 start on late WE", {mem_wr, wr_start}, 2'b11);
    step();
    chk("R8 start pulse ends", {mem_wr, wr_start}, 2'b10);
    ext_ce_n = 1; ext_we_n = 1; step();
    ext_we_n = 0; step();
    chk("R7 WE alone deselects", {int_ce_n, mem_wr}, 2'b10);
    ext_ce_n = 0;
    #1 chk("R8 start on late CE", {mem_wr, wr_start}, 2'b11);
    step();
    chk("R8 single cycle pulse", wr_start, 0);
    ext_ce_n = 1; ext_we_n = 1; step();

    vcc_lt_pf = 1; vcc_lt_so = 0;
    for (int i = 0; i < 40; i++) begin
      {ext_ce_n, ext_oe_n, ext_we_n} = 3'($urandom_range(0, 7));
      #1;
      chk("R1 blocked in fault", {int_ce_n, mem_rd, mem_wr, dq_oe, wr_start}, 5'b10000);
      chk("R2 reset in fault", rst_out_n, 0);
      step();
    end
    ext_ce_n = 1; ext_oe_n = 1; ext_we_n = 1;
    #1 chk("R5 above battery level stays on mains", bat_sel, 0);
    vcc_lt_so = 1;
    #1 chk("R5 below both levels selects backup", bat_sel, 1);
    step();
    vcc_lt_pf = 0;
    #1 chk("R5 only battery comparator set", bat_sel, 0);
    step();

    rst_n = 0; step(); rst_n = 1; step();
    chk("R6 armed survives reset", armed, 1);
    step();
    chk("R9 reset low after rst_n", rst_out_n, 0);
    give_ticks(REC);
    chk("R9 released after recovery", rst_out_n, 1);

    vcc_lt_pf = 1; vcc_lt_so = 1; step();
    cold_n = 0; #1;
    chk("R6 cold start disarms", armed, 0);
    chk("R5 disarmed no backup", bat_sel, 0);
    step(); cold_n = 1; step();
    chk("R6 no rearm while supply low", armed, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule